// File: doc/BRIEF.md
# TDM Frame Boundary Aligner

This block finds the frame boundary of a serial time-division-multiplexed bus. It takes the bus bit clock and the frame pulse as plain inputs and samples both with a faster free-running system clock. From them it produces a one-cycle frame-start strobe, a running count of bit periods since the last boundary, and a one-cycle alignment error. Four static configuration inputs set the boundary rule at run time: the bit clock rate (three legal codes), whether the pulse is active-low or active-high, whether the pulse is centred on the boundary or begins at it, and which bit clock edge marks the boundary.

Every decision is made in the system clock domain. Each input passes through a two-flop synchronizer followed by one history flop, so edges appear as a change between successive samples. A "decision edge" is the bit clock edge at which the pulse is examined. It is the boundary edge when the pulse is centred on the boundary. When the pulse begins at the boundary, it is the opposite edge that follows the boundary, because that edge falls in the middle of the pulse. The bit counter advances on every decision edge. A frame holds 125 µs of bits, so its length depends on the rate.

Top module: `tdm_frame_align`

## Requirements
- R1: Rate code 2'b00 gives a frame of 2048 decision edges, 2'b01 gives 1024 and 2'b10 gives 512. While locked, the counter runs from 0 up to the frame length minus one.
- R2: With the position select (`start_pos_i`) at 0, the decision edge is the boundary edge. A pulse counts only if it reads active in both of the last two synchronized samples at that edge.
- R3: With the position select at 1, the decision edge is the first opposite-polarity bit clock edge after the boundary. The same two-sample active test applies at that edge.
- R4: With `rise_edge_i` at 0, a falling bit clock edge is the boundary edge. With `rise_edge_i` at 1, a rising edge is the boundary edge.
- R5: With `pulse_hi_i` at 0 the frame pulse is active when low. With `pulse_hi_i` at 1 it is active when high.
- R6: When unlocked, the first qualifying pulse gives `frame_start_o` high for one cycle, and `bit_count_o` reads 0 at that moment. Both outputs change three system clock edges after the input edge is first sampled. Each later decision edge then adds one to the counter.
- R7: If the locked counter reaches its last value at a decision edge and no qualifying pulse is present, `align_err_o` is high for one cycle. The counter returns to 0, lock is lost and no strobe is given. The next qualifying pulse re-acquires lock.
- R8: If a qualifying pulse appears while locked with the counter below its last value, `align_err_o` is high for one cycle. The counter returns to 0 and lock is lost.
- R9: While the rate code is 2'b11, `cfg_err_o` is high (one cycle after the code is applied), the counter holds 0, and neither strobes nor alignment errors are produced.
- R10: Any change of a configuration input clears lock and the counter. The next qualifying pulse is then treated as a fresh acquisition and never as an error.
- R11: While `rst_n` is low, and for two system clock edges after it rises, all outputs are 0.
- R12: `frame_start_o` and `align_err_o` are never high in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_clk_i | input | 1 | Bus bit clock, asynchronous to `clk` |
| frame_pulse_i | input | 1 | Bus frame pulse, asynchronous to `clk` |
| rate_sel_i | input | 2 | Bit clock rate code (00 fastest, 10 slowest, 11 reserved) |
| start_pos_i | input | 1 | 0: pulse centred on the boundary; 1: pulse begins at the boundary |
| rise_edge_i | input | 1 | 0: falling edge marks the boundary; 1: rising edge marks it |
| pulse_hi_i | input | 1 | 0: active-low pulse; 1: active-high pulse |
| frame_start_o | output | 1 | One-cycle strobe on an accepted boundary |
| bit_count_o | output | 11 | Decision edges since the last boundary |
| align_err_o | output | 1 | One-cycle flag for a missing or misplaced pulse |
| cfg_err_o | output | 1 | Reserved rate code selected |

## Verification
The hardest states to reach from the ports are a pulse that lands in the middle of a locked frame, and a configuration change while the block is locked, followed by a pulse that would be misplaced under the old lock. The bench builds its bit clock and frame pulse from a list of pulse positions counted in bit periods. Positions can be dropped or added one at a time, and runs are chained so that one run starts while the previous configuration is still locked. A behavioural model that tracks the synchronizer delay and the lock rules predicts the strobe, counter and flags on every system clock.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;

  typedef enum logic [1:0] {
    RATE_FAST = 2'b00,
    RATE_MID  = 2'b01,
    RATE_SLOW = 2'b10,
    RATE_RSVD = 2'b11
  } rate_e;

  typedef struct packed {
    rate_e rate;
    logic  start_pos;
    logic  rise_edge;
    logic  pulse_hi;
  } align_cfg_t;

endpackage

// File: rtl/tdm_sync_edge.sv
module tdm_sync_edge #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);

  localparam int CHAIN = STAGES + 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [CHAIN-1:0] chain_q;
    logic [CHAIN-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[CHAIN-2:0], async_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign lvl_o[g]  = chain_q[STAGES-1];
    assign prev_o[g] = chain_q[STAGES];
  end

endmodule

// File: rtl/tdm_edge_select.sv
module tdm_edge_select
  import tdm_align_pkg::*;
(
  input  align_cfg_t cfg_i,
  input  logic       ck_lvl_i,
  input  logic       ck_prev_i,
  input  logic       fp_lvl_i,
  input  logic       fp_prev_i,
  output logic       dec_edge_o,
  output logic       pulse_hit_o
);

  logic ck_rise;
  logic ck_fall;
  logic bnd_edge;
  logic opp_edge;
  logic fp_act_now;
  logic fp_act_prev;

  always_comb begin
    ck_rise     = ck_lvl_i & ~ck_prev_i;
    ck_fall     = ~ck_lvl_i & ck_prev_i;
    bnd_edge    = cfg_i.rise_edge ? ck_rise : ck_fall;
    opp_edge    = cfg_i.rise_edge ? ck_fall : ck_rise;
    dec_edge_o  = cfg_i.start_pos ? opp_edge : bnd_edge;
    fp_act_now  = cfg_i.pulse_hi ? fp_lvl_i  : ~fp_lvl_i;
    fp_act_prev = cfg_i.pulse_hi ? fp_prev_i : ~fp_prev_i;
    pulse_hit_o = dec_edge_o & fp_act_now & fp_act_prev;
  end

endmodule

// File: rtl/tdm_frame_track.sv
module tdm_frame_track
  import tdm_align_pkg::*;
#(
  parameter int BASE_BITS = 2048,
  parameter int CNT_W     = $clog2(BASE_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  align_cfg_t       cfg_i,
  input  logic             dec_edge_i,
  input  logic             pulse_hit_i,
  output logic             strobe_o,
  output logic [CNT_W-1:0] count_o,
  output logic             err_o,
  output logic             cfg_err_o
);

  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(BASE_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_MID  = CNT_W'(BASE_BITS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(BASE_BITS / 4 - 1);

  align_cfg_t       cfg_q;
  logic             locked_q, locked_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             strobe_q, strobe_d;
  logic             err_q, err_d;
  logic             cfg_err_q;

  logic             cfg_chg;
  logic             rsvd;
  logic             at_wrap;
  logic             state_en;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    unique case (cfg_i.rate)
      RATE_FAST: last_idx = LAST_FAST;
      RATE_MID:  last_idx = LAST_MID;
      RATE_SLOW: last_idx = LAST_SLOW;
      default:   last_idx = '0;
    endcase
  end

  always_comb begin
    cfg_chg  = (cfg_i != cfg_q);
    rsvd     = (cfg_i.rate == RATE_RSVD);
    at_wrap  = (cnt_q == last_idx);
    state_en = cfg_chg | rsvd | dec_edge_i;

    locked_d = locked_q;
    cnt_d    = cnt_q;
    strobe_d = 1'b0;
    err_d    = 1'b0;

    if (cfg_chg || rsvd) begin
      locked_d = 1'b0;
      cnt_d    = '0;
    end else if (dec_edge_i) begin
      if (!locked_q) begin
        if (pulse_hit_i) begin
          locked_d = 1'b1;
          cnt_d    = '0;
          strobe_d = 1'b1;
        end
      end else if (at_wrap) begin
        cnt_d = '0;
        if (pulse_hit_i) begin
          strobe_d = 1'b1;
        end else begin
          err_d    = 1'b1;
          locked_d = 1'b0;
        end
      end else if (pulse_hit_i) begin
        err_d    = 1'b1;
        locked_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      locked_q  <= 1'b0;
      cnt_q     <= '0;
      strobe_q  <= 1'b0;
      err_q     <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      strobe_q  <= strobe_d;
      err_q     <= err_d;
      cfg_err_q <= rsvd;
      if (cfg_chg) begin
        cfg_q <= cfg_i;
      end
      if (state_en) begin
        locked_q <= locked_d;
        cnt_q    <= cnt_d;
      end
    end
  end

  assign strobe_o  = strobe_q;
  assign count_o   = cnt_q;
  assign err_o     = err_q;
  assign cfg_err_o = cfg_err_q;

endmodule

// File: rtl/tdm_frame_align.sv
module tdm_frame_align
  import tdm_align_pkg::*;
#(
  parameter int BASE_BITS   = 2048,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(BASE_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_clk_i,
  input  logic             frame_pulse_i,
  input  logic [1:0]       rate_sel_i,
  input  logic             start_pos_i,
  input  logic             rise_edge_i,
  input  logic             pulse_hi_i,
  output logic             frame_start_o,
  output logic [CNT_W-1:0] bit_count_o,
  output logic             align_err_o,
  output logic             cfg_err_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  align_cfg_t cfg;
  logic [1:0] s_lvl;
  logic [1:0] s_prev;
  logic       dec_edge;
  logic       pulse_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[1];

  always_comb begin
    cfg.rate      = rate_e'(rate_sel_i);
    cfg.start_pos = start_pos_i;
    cfg.rise_edge = rise_edge_i;
    cfg.pulse_hi  = pulse_hi_i;
  end

  tdm_sync_edge #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({frame_pulse_i, bit_clk_i}),
    .lvl_o   (s_lvl),
    .prev_o  (s_prev)
  );

  tdm_edge_select u_sel (
    .cfg_i       (cfg),
    .ck_lvl_i    (s_lvl[0]),
    .ck_prev_i   (s_prev[0]),
    .fp_lvl_i    (s_lvl[1]),
    .fp_prev_i   (s_prev[1]),
    .dec_edge_o  (dec_edge),
    .pulse_hit_o (pulse_hit)
  );

  tdm_frame_track #(
    .BASE_BITS (BASE_BITS),
    .CNT_W     (CNT_W)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cfg_i       (cfg),
    .dec_edge_i  (dec_edge),
    .pulse_hit_i (pulse_hit),
    .strobe_o    (frame_start_o),
    .count_o     (bit_count_o),
    .err_o       (align_err_o),
    .cfg_err_o   (cfg_err_o)
  );

endmodule

// File: rtl/tdm_frame_align_chk.sv
module tdm_frame_align_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start_o,
  input logic             align_err_o,
  input logic             cfg_err_o,
  input logic [CNT_W-1:0] bit_count_o,
  input logic             dec_edge
);

  // R12
  strobe_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start_o && align_err_o));

  // R12
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);

  // R12
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |=> !align_err_o);

  // R9
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (!frame_start_o && !align_err_o && bit_count_o == '0));

  // R6
  strobe_zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> bit_count_o == '0);

  // R6
  strobe_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> $past(dec_edge));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_count_o != $past(bit_count_o)) |->
      (bit_count_o == '0 || bit_count_o == CNT_W'($past(bit_count_o) + 1'b1)));

  // R7
  err_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |-> bit_count_o == '0);

endmodule

bind tdm_frame_align tdm_frame_align_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start_o (frame_start_o),
  .align_err_o   (align_err_o),
  .cfg_err_o     (cfg_err_o),
  .bit_count_o   (bit_count_o),
  .dec_edge      (dec_edge)
);

// File: tb/tdm_frame_align_tb.sv
module tdm_frame_align_tb;

  localparam int HALF = 4;

  logic        clk;
  logic        rst_n;
  logic        bclk;
  logic        fpin;
  logic [1:0]  cfg_rate;
  logic        cfg_start;
  logic        cfg_rise;
  logic        cfg_phi;
  logic        frame_start_o;
  logic [10:0] bit_count_o;
  logic        align_err_o;
  logic        cfg_err_o;

  int    n_checks = 0;
  int    n_bad = 0;
  int    n_strb = 0;
  int    n_err = 0;
  bit    done = 0;
  string cur_req = "R11";

  tdm_frame_align u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_clk_i     (bclk),
    .frame_pulse_i (fpin),
    .rate_sel_i    (cfg_rate),
    .start_pos_i   (cfg_start),
    .rise_edge_i   (cfg_rise),
    .pulse_hi_i    (cfg_phi),
    .frame_start_o (frame_start_o),
    .bit_count_o   (bit_count_o),
    .align_err_o   (align_err_o),
    .cfg_err_o     (cfg_err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Behavioural reference model
  logic h_ck [3];
  logic h_fp [3];
  int   rel_cnt;
  bit   m_locked;
  int   m_cnt;
  bit   m_strb, m_err, m_cerr;
  logic [4:0] m_cfg_prev;

  always @(posedge clk) begin
    logic [4:0] cfg_now;
    bit rise, fall, bnd, opp, dec, hit;
    int flen;
    if (!rst_n) rel_cnt = 0;
    else if (rel_cnt < 3) rel_cnt++;
    if (rel_cnt < 3) begin
      for (int i = 0; i < 3; i++) begin h_ck[i] = 1'b0; h_fp[i] = 1'b0; end
      m_locked = 0; m_cnt = 0; m_strb = 0; m_err = 0; m_cerr = 0;
      m_cfg_prev = '0;
    end else begin
      cfg_now = {cfg_rate, cfg_start, cfg_rise, cfg_phi};
      rise = h_ck[1] && !h_ck[2];
      fall = !h_ck[1] && h_ck[2];
      bnd  = cfg_rise ? rise : fall;
      opp  = cfg_rise ? fall : rise;
      dec  = cfg_start ? opp : bnd;
      hit  = dec && (h_fp[1] == cfg_phi) && (h_fp[2] == cfg_phi);
      flen = (cfg_rate == 2'b11) ? 1 : (2048 >> cfg_rate);
      m_strb = 0; m_err = 0;
      if (cfg_now != m_cfg_prev || cfg_rate == 2'b11) begin
        m_locked = 0; m_cnt = 0;
        m_cfg_prev = cfg_now;
      end else if (dec) begin
        if (!m_locked) begin
          if (hit) begin m_locked = 1; m_cnt = 0; m_strb = 1; end
        end else if (m_cnt == flen - 1) begin
          m_cnt = 0;
          if (hit) m_strb = 1;
          else begin m_err = 1; m_locked = 0; end
        end else if (hit) begin
          m_err = 1; m_locked = 0; m_cnt = 0;
        end else begin
          m_cnt++;
        end
      end
      m_cerr = (cfg_rate == 2'b11);
      h_ck[2] = h_ck[1]; h_ck[1] = h_ck[0]; h_ck[0] = bclk;
      h_fp[2] = h_fp[1]; h_fp[1] = h_fp[0]; h_fp[0] = fpin;
    end
  end

  task automatic check_bit(input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check_bit("frame_start_o", int'(frame_start_o), int'(m_strb));
      check_bit("bit_count_o", int'(bit_count_o), m_cnt);
      check_bit("align_err_o", int'(align_err_o), int'(m_err));
      check_bit("cfg_err_o", int'(cfg_err_o), int'(m_cerr));
      if (frame_start_o) n_strb++;
      if (align_err_o) n_err++;
    end
  end

  function automatic bit is_pulse(int b, int per, int off, int drop, int extra);
    return ((b >= off) && ((b - off) % per == 0) && (b != drop)) || (b == extra);
  endfunction

  task automatic run_frames(input string req, input logic [1:0] rate,
                            input logic pos, input logic ckp, input logic fpp,
                            input int nbits, input int per, input int off,
                            input int drop, input int extra,
                            input int exp_strb, input int exp_err);
    int s0, e0;
    cur_req   = req;
    cfg_rate  = rate;
    cfg_start = pos;
    cfg_rise  = ckp;
    cfg_phi   = fpp;
    bclk      = ~ckp;
    fpin      = ~fpp;
    s0 = n_strb;
    e0 = n_err;
    repeat (8) @(negedge clk);
    if (!pos && is_pulse(0, per, off, drop, extra)) fpin = fpp;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      bclk = ckp;
      if (pos) fpin = is_pulse(b, per, off, drop, extra) ? fpp : ~fpp;
      repeat (HALF) @(negedge clk);
      bclk = ~ckp;
      if (!pos) fpin = is_pulse(b + 1, per, off, drop, extra) ? fpp : ~fpp;
      repeat (HALF) @(negedge clk);
    end
    fpin = ~fpp;
    repeat (6) @(negedge clk);
    check_bit("strobe count", n_strb - s0, exp_strb);
    check_bit("error count", n_err - e0, exp_err);
  endtask

  initial begin
    rst_n     = 1'b0;
    bclk      = 1'b0;
    fpin      = 1'b1;
    cfg_rate  = 2'b00;
    cfg_start = 1'b0;
    cfg_rise  = 1'b0;
    cfg_phi   = 1'b0;
    repeat (4) @(negedge clk);
    cur_req = "R11";
    check_bit("reset frame_start_o", int'(frame_start_o), 0);
    check_bit("reset bit_count_o", int'(bit_count_o), 0);
    check_bit("reset align_err_o", int'(align_err_o), 0);
    check_bit("reset cfg_err_o", int'(cfg_err_o), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2 R4 R5 R6 R12: centred pulse, falling edge, active-low, 512-bit frames
    run_frames("R2/R4/R5/R6/R12", 2'b10, 1'b0, 1'b0, 1'b0, 1100, 512, 0, -1, -1, 3, 0);
    // R3 R4 R5: pulse begins at boundary, rising edge, active-high
    run_frames("R3/R4/R5", 2'b10, 1'b1, 1'b1, 1'b1, 1100, 512, 0, -1, -1, 3, 0);
    // R7: pulse at bit 512 omitted
    run_frames("R7", 2'b10, 1'b0, 1'b0, 1'b0, 1600, 512, 0, 512, -1, 3, 1);
    // R1: 1024-bit frames
    run_frames("R1/R2", 2'b01, 1'b0, 1'b1, 1'b1, 2100, 1024, 0, -1, -1, 3, 0);
    // R8: extra pulse at bit 200
    run_frames("R8", 2'b10, 1'b0, 1'b0, 1'b0, 1100, 512, 0, -1, 200, 3, 1);
    // R1: 2048-bit frames
    run_frames("R1/R3", 2'b00, 1'b1, 1'b0, 1'b0, 4200, 2048, 0, -1, -1, 3, 0);
    // R9: reserved rate code
    run_frames("R9", 2'b11, 1'b0, 1'b0, 1'b1, 600, 512, 0, -1, -1, 0, 0);
    cur_req = "R9";
    check_bit("cfg_err_o held", int'(cfg_err_o), 1);
    // R10: lock, then change polarity; pulse at 100 must be a fresh acquisition
    run_frames("R10", 2'b10, 1'b0, 1'b1, 1'b0, 300, 512, 0, -1, -1, 1, 0);
    run_frames("R10", 2'b10, 1'b0, 1'b1, 1'b1, 700, 512, 100, -1, -1, 2, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_bad++;
      $display("FAIL %s watchdog expired got=running exp=finished", cur_req);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule